// File: doc/BRIEF.md
# Pin Edge Capture, Interrupt Grouping and Wake Unit

This unit watches a vector of general-purpose pins organised in banks of 32. Each pin arrives asynchronously and is brought into the clock domain through two flops. A third register holds the previous synchronised level, so that rising and falling changes can be seen. Pins that software has set up as inputs may latch a sticky status bit on a rising change, on a falling change or on both, according to two per-pin enable vectors. Software clears a status bit by writing a one to it through a bank-indexed clear port. It reads the status back, one bank at a time, through a combinational read port.

The status is turned into three registered interrupt levels. Two lines are dedicated to pins 0 and 1 of bank 0. The third line is shared by every other pin. A separate one-cycle wake request fires when the processor reports that it is halted and an input pin that belongs to a fixed wake-source set changes level. Pins at or above the implemented line count never produce status or wake events.

Top module: `edge_irq_wake`

## Requirements
- R1: When an input pin (direction bit 0) with its rising enable set goes from 0 to 1, its status bit becomes 1. The bit is visible on the read port after the third rising clock edge that follows the pin change.
- R2: When an input pin with its falling enable set goes from 1 to 0, its status bit becomes 1, with the same latency as R1. A change in a direction whose enable is clear, or no change at all, sets nothing.
- R3: A pin whose direction bit is 1 (output) never sets its status bit, whatever its enables and level changes.
- R4: Status bits are sticky. When `clr_we` is 1, each one in `clr_data` clears the matching bit of bank `clr_bank` at the clock edge, and each zero leaves its bit unchanged.
- R5: If a new qualifying edge and a clear of the same bit occur at the same clock edge, the bit ends up set.
- R6: `irq_pin0` and `irq_pin1` are registered copies of bank 0 status bits 0 and 1. Each rises one cycle after its bit is set and falls one cycle after its bit is cleared.
- R7: `irq_rest` is a registered OR of bank 0 status bits 2 to 31 and every status bit of the higher banks.
- R8: `wake_req` is high for one cycle, at the same edge where status would be set, when `cpu_halted` is 1 and an input pin in the wake set changes level in either direction. This happens whatever the edge enables are. The wake sets for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F; higher banks have none.
- R9: Pins whose index is NUM_LINES or above set no status bit and raise no wake request.
- R10: `rd_status` shows the status word of bank `rd_bank`. A bank index at or beyond NUM_BANKS reads 0, and a clear aimed at such an index changes nothing.
- R11: After reset, all status bits, all interrupt lines and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | NUM_BANKS*32 | Asynchronous pin levels |
| pin_dir | input | NUM_BANKS*32 | Direction per pin, 1 = output |
| rise_en | input | NUM_BANKS*32 | Rising-edge capture enable per pin |
| fall_en | input | NUM_BANKS*32 | Falling-edge capture enable per pin |
| cpu_halted | input | 1 | Processor is halted |
| clr_we | input | 1 | Clear write strobe |
| clr_bank | input | BANK_SEL_W | Bank addressed by the clear write |
| clr_data | input | 32 | Write-one-to-clear mask |
| rd_bank | input | BANK_SEL_W | Bank selected for status readback |
| rd_status | output | 32 | Status word of the selected bank |
| irq_pin0 | output | 1 | Interrupt for bank 0 pin 0 |
| irq_pin1 | output | 1 | Interrupt for bank 0 pin 1 |
| irq_rest | output | 1 | Shared interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake request while halted |

## Verification
The vector table puts single pins through each combination of direction, enable and level change. A rise, a fall, an unchanged level, an output pin and an unimplemented pin are each tried against both matching and non-matching enables, so that a swapped enable, a missing direction qualifier or a missing line limit shows up as a wrong status bit. The directed tests then pick pins that route to each of the three interrupt lines, so that a misrouted group is caught. They also use partial and zero clear masks and a clear that lands on the same edge as a new event. Wake is tried with pins inside and outside the wake set, with the processor running and halted, and with a pin set as an output.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int BANK_W = 32;

    typedef logic [BANK_W-1:0] bank_word_t;

    // Per-bank level-change decomposition
    typedef struct packed {
        bank_word_t rise;
        bank_word_t fall;
    } bank_edge_t;

    // Fixed wake-source set per bank
    function automatic bank_word_t wake_mask(input int bank);
        case (bank)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            3:       return 32'h0012_007F;
            default: return '0;
        endcase
    endfunction

    // Pins of a bank that lie below the implemented line count
    function automatic bank_word_t impl_mask(input int bank, input int lines);
        bank_word_t m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (bank * BANK_W + i < lines) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_prev
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl      = sync_q;
    assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int LINES    = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_word_t lvl,
    input  bank_word_t lvl_prev,
    input  bank_word_t dir,
    input  bank_word_t rise_en,
    input  bank_word_t fall_en,
    input  bank_word_t clr_mask,
    output bank_word_t status,
    output logic       wake_hit
);
    localparam bank_word_t IMPL = impl_mask(BANK_IDX, LINES);
    localparam bank_word_t WAKE = wake_mask(BANK_IDX);

    bank_edge_t edge_w;
    bank_word_t live;
    bank_word_t set_w;
    bank_word_t stat_q;

    always_comb begin
        edge_w.rise = lvl & ~lvl_prev;
        edge_w.fall = ~lvl & lvl_prev;
        live        = ~dir & IMPL;
        set_w       = live & ((edge_w.rise & rise_en) | (edge_w.fall & fall_en));
        wake_hit    = |((edge_w.rise | edge_w.fall) & live & WAKE);
    end

    // A new event outranks a clear of the same bit
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_mask) | set_w;
    end

    assign status = stat_q;
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
    parameter int NUM_BANKS = 4,
    parameter int WIDTH     = NUM_BANKS * 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WIDTH-1:0]     status,
    input  logic                 cpu_halted,
    input  logic [NUM_BANKS-1:0] wake_hits,
    output logic                 irq_pin0,
    output logic                 irq_pin1,
    output logic                 irq_rest,
    output logic                 wake_req
);
    logic [WIDTH-1:0] rest_bits;

    always_comb begin
        rest_bits      = status;
        rest_bits[1:0] = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pin0 <= 1'b0;
            irq_pin1 <= 1'b0;
            irq_rest <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            irq_pin0 <= status[0];
            irq_pin1 <= status[1];
            irq_rest <= |rest_bits;
            wake_req <= cpu_halted & (|wake_hits);
        end
    end
endmodule

// File: rtl/edge_irq_wake.sv
module edge_irq_wake
    import gpio_evt_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_LINES  = 116,
    parameter int BANK_SEL_W = 3,
    localparam int NPIN      = NUM_BANKS * BANK_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPIN-1:0]       pin_async,
    input  logic [NPIN-1:0]       pin_dir,
    input  logic [NPIN-1:0]       rise_en,
    input  logic [NPIN-1:0]       fall_en,
    input  logic                  cpu_halted,
    input  logic                  clr_we,
    input  logic [BANK_SEL_W-1:0] clr_bank,
    input  logic [BANK_W-1:0]     clr_data,
    input  logic [BANK_SEL_W-1:0] rd_bank,
    output logic [BANK_W-1:0]     rd_status,
    output logic                  irq_pin0,
    output logic                  irq_pin1,
    output logic                  irq_rest,
    output logic                  wake_req
);
    logic [NPIN-1:0]      lvl;
    logic [NPIN-1:0]      lvl_prev;
    logic [NPIN-1:0]      stat_q;
    logic [NUM_BANKS-1:0] wake_hits;
    bank_word_t           bank_stat [NUM_BANKS];

    gpio_evt_sync #(.WIDTH(NPIN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_async(pin_async),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_word_t clr_mask;
        assign clr_mask = (clr_we && clr_bank == BANK_SEL_W'(b)) ? clr_data : '0;

        gpio_evt_bank #(.BANK_IDX(b), .LINES(NUM_LINES)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .lvl     (lvl[b*BANK_W +: BANK_W]),
            .lvl_prev(lvl_prev[b*BANK_W +: BANK_W]),
            .dir     (pin_dir[b*BANK_W +: BANK_W]),
            .rise_en (rise_en[b*BANK_W +: BANK_W]),
            .fall_en (fall_en[b*BANK_W +: BANK_W]),
            .clr_mask(clr_mask),
            .status  (bank_stat[b]),
            .wake_hit(wake_hits[b])
        );

        assign stat_q[b*BANK_W +: BANK_W] = bank_stat[b];
    end

    always_comb begin
        rd_status = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank == BANK_SEL_W'(b)) rd_status = bank_stat[b];
        end
    end

    gpio_evt_irq #(.NUM_BANKS(NUM_BANKS), .WIDTH(NPIN)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .status    (stat_q),
        .cpu_halted(cpu_halted),
        .wake_hits (wake_hits),
        .irq_pin0  (irq_pin0),
        .irq_pin1  (irq_pin1),
        .irq_rest  (irq_rest),
        .wake_req  (wake_req)
    );
endmodule

// File: rtl/edge_irq_wake_chk.sv
module edge_irq_wake_chk #(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_LINES  = 116,
    parameter int BANK_SEL_W = 3,
    localparam int NPIN      = NUM_BANKS * 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NPIN-1:0]       pin_dir,
    input logic                  cpu_halted,
    input logic                  clr_we,
    input logic [BANK_SEL_W-1:0] clr_bank,
    input logic [31:0]           clr_data,
    input logic [NPIN-1:0]       stat_q,
    input logic                  irq_pin0,
    input logic                  irq_pin1,
    input logic                  irq_rest,
    input logic                  wake_req
);
    logic [NPIN-1:0] clr_full;
    logic [NPIN-1:0] unimpl;

    always_comb begin
        clr_full = '0;
        unimpl   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (clr_we && int'(clr_bank) == b) clr_full[b*32 +: 32] = clr_data;
        end
        for (int i = 0; i < NPIN; i++) begin
            if (i >= NUM_LINES) unimpl[i] = 1'b1;
        end
    end

    p_output_no_set_r3: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q) & $past(pin_dir)) == '0));

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (($past(stat_q) & ~stat_q & ~$past(clr_full)) == '0));

    p_irq0_follow_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_pin0 == $past(stat_q[0])));

    p_irq1_follow_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_pin1 == $past(stat_q[1])));

    p_rest_group_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_rest == (|($past(stat_q) & ~NPIN'(3)))));

    p_wake_halted_r8: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(cpu_halted));

    p_unimpl_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & unimpl) == '0));
endmodule

bind edge_irq_wake edge_irq_wake_chk #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_LINES (NUM_LINES),
    .BANK_SEL_W(BANK_SEL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_dir   (pin_dir),
    .cpu_halted(cpu_halted),
    .clr_we    (clr_we),
    .clr_bank  (clr_bank),
    .clr_data  (clr_data),
    .stat_q    (stat_q),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_rest  (irq_rest),
    .wake_req  (wake_req)
);

// File: tb/tb_edge_irq_wake.sv
module tb_edge_irq_wake;
    localparam int NB   = 4;
    localparam int NL   = 116;
    localparam int SW   = 3;
    localparam int NPIN = NB * 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NPIN-1:0] pin_async = '0;
    logic [NPIN-1:0] pin_dir = '0;
    logic [NPIN-1:0] rise_en = '0;
    logic [NPIN-1:0] fall_en = '0;
    logic            cpu_halted = 1'b0;
    logic            clr_we = 1'b0;
    logic [SW-1:0]   clr_bank = '0;
    logic [31:0]     clr_data = '0;
    logic [SW-1:0]   rd_bank = '0;
    logic [31:0]     rd_status;
    logic            irq_pin0, irq_pin1, irq_rest, wake_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    edge_irq_wake #(.NUM_BANKS(NB), .NUM_LINES(NL), .BANK_SEL_W(SW)) dut (
        .clk(clk), .rst(rst), .pin_async(pin_async), .pin_dir(pin_dir),
        .rise_en(rise_en), .fall_en(fall_en), .cpu_halted(cpu_halted),
        .clr_we(clr_we), .clr_bank(clr_bank), .clr_data(clr_data),
        .rd_bank(rd_bank), .rd_status(rd_status), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_rest(irq_rest), .wake_req(wake_req)
    );

    // {pin[7:0], dir, rise, fall, level, expected status bit}
    localparam logic [12:0] VEC [0:11] = '{
        {8'd5,   5'b01011},  // R1 rise enabled
        {8'd5,   5'b01000},  // R2 fall, only rise enabled
        {8'd5,   5'b00110},  // R1 rise, only fall enabled
        {8'd5,   5'b00101},  // R2 fall enabled
        {8'd40,  5'b11110},  // R3 output pin rising
        {8'd40,  5'b11100},  // R3 output pin falling
        {8'd70,  5'b01111},  // R1 both enabled, bank 2
        {8'd70,  5'b01110},  // R2 no level change
        {8'd118, 5'b01110},  // R9 unimplemented pin
        {8'd0,   5'b01011},  // R1 pin 0
        {8'd1,   5'b00110},  // R1 pin 1 rise, fall only
        {8'd1,   5'b00101}   // R2 pin 1 fall
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_bank(input int b, output logic [31:0] v);
        rd_bank = SW'(b);
        #1;
        v = rd_status;
    endtask

    task automatic clear_all();
        for (int b = 0; b < NB; b++) begin
            clr_we = 1'b1; clr_bank = SW'(b); clr_data = '1;
            tick(1);
        end
        clr_we = 1'b0; clr_data = '0;
    endtask

    task automatic cfg_pin(input int p, input logic d, input logic r, input logic f);
        pin_dir = '0; rise_en = '0; fall_en = '0;
        pin_dir[p] = d; rise_en[p] = r; fall_en[p] = f;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R11 reset state
        check("R11 irq/wake", {28'd0, irq_pin0, irq_pin1, irq_rest, wake_req}, 32'd0);
        for (int b = 0; b < NB; b++) begin
            read_bank(b, v);
            check("R11 status", v, 32'd0);
        end

        // Vector table
        for (int i = 0; i < 12; i++) begin
            int p;
            p = int'(VEC[i][12:5]);
            clear_all();
            cfg_pin(p, VEC[i][4], VEC[i][3], VEC[i][2]);
            pin_async[p] = VEC[i][1];
            tick(3);
            read_bank(p / 32, v);
            check($sformatf("R1/R2/R3/R9 vec%0d", i), {31'd0, v[p % 32]}, {31'd0, VEC[i][0]});
        end

        // R6 pin 0 line
        clear_all();
        cfg_pin(0, 1'b0, 1'b0, 1'b0);
        pin_async[0] = 1'b0;
        tick(3);
        cfg_pin(0, 1'b0, 1'b1, 1'b0);
        pin_async[0] = 1'b1;
        tick(3);
        check("R6 irq0 not yet", {31'd0, irq_pin0}, 32'd0);
        tick(1);
        check("R6 irq0 set", {29'd0, irq_pin0, irq_pin1, irq_rest}, 32'b100);
        clr_we = 1'b1; clr_bank = 0; clr_data = 32'h1;
        tick(1);
        clr_we = 1'b0;
        read_bank(0, v);
        check("R4 bit0 cleared", v, 32'd0);
        check("R6 irq0 lags clear", {31'd0, irq_pin0}, 32'd1);
        tick(1);
        check("R6 irq0 dropped", {31'd0, irq_pin0}, 32'd0);

        // R6 pin 1 line
        cfg_pin(1, 1'b0, 1'b1, 1'b0);
        pin_async[1] = 1'b1;
        tick(4);
        check("R6 irq1 set", {29'd0, irq_pin0, irq_pin1, irq_rest}, 32'b010);
        clear_all();

        // R7 shared line
        cfg_pin(2, 1'b0, 1'b1, 1'b0);
        pin_async[2] = 1'b1;
        tick(4);
        check("R7 pin2 shared", {29'd0, irq_pin0, irq_pin1, irq_rest}, 32'b001);
        clear_all();
        tick(1);
        check("R7 shared dropped", {31'd0, irq_rest}, 32'd0);
        cfg_pin(70, 1'b0, 1'b0, 1'b1);
        pin_async[70] = 1'b0;
        tick(4);
        check("R7 bank2 shared", {29'd0, irq_pin0, irq_pin1, irq_rest}, 32'b001);
        clear_all();

        // R4 partial and zero clears, R10 out-of-range bank
        pin_dir = '0; rise_en = '0; fall_en = '0;
        rise_en[3] = 1'b1; rise_en[4] = 1'b1;
        pin_async[3] = 1'b1; pin_async[4] = 1'b1;
        tick(3);
        read_bank(0, v);
        check("R4 both set", v & 32'h18, 32'h18);
        clr_we = 1'b1; clr_bank = 0; clr_data = 32'h0;
        tick(1);
        read_bank(0, v);
        check("R4 zero clear", v & 32'h18, 32'h18);
        clr_bank = 3'd5; clr_data = '1;
        tick(1);
        read_bank(0, v);
        check("R10 clear bad bank", v & 32'h18, 32'h18);
        clr_bank = 0; clr_data = 32'h08;
        tick(1);
        clr_we = 1'b0;
        read_bank(0, v);
        check("R4 partial clear", v & 32'h18, 32'h10);
        read_bank(5, v);
        check("R10 bad bank reads 0", v, 32'd0);
        clear_all();

        // R5 edge beats clear
        cfg_pin(6, 1'b0, 1'b1, 1'b1);
        pin_async[6] = 1'b1;
        tick(3);
        pin_async[6] = 1'b0;
        tick(2);
        clr_we = 1'b1; clr_bank = 0; clr_data = 32'h40;
        tick(1);
        clr_we = 1'b0;
        read_bank(0, v);
        check("R5 edge wins", {31'd0, v[6]}, 32'd1);
        clr_we = 1'b1;
        tick(1);
        clr_we = 1'b0;
        read_bank(0, v);
        check("R4 plain clear", {31'd0, v[6]}, 32'd0);

        // R8 wake
        clear_all();
        pin_dir = '0; rise_en = '0; fall_en = '0;
        cpu_halted = 1'b1;
        pin_async[0] = 1'b0;
        tick(2);
        check("R8 wake early", {31'd0, wake_req}, 32'd0);
        tick(1);
        check("R8 wake pin0", {31'd0, wake_req}, 32'd1);
        tick(1);
        check("R8 wake one cycle", {31'd0, wake_req}, 32'd0);
        pin_async[2] = 1'b0;
        tick(3);
        check("R8 pin2 outside set", {31'd0, wake_req}, 32'd0);
        pin_async[113] = 1'b1;
        tick(3);
        check("R8 wake pin113", {31'd0, wake_req}, 32'd1);
        cpu_halted = 1'b0;
        pin_async[113] = 1'b0;
        tick(3);
        check("R8 running no wake", {31'd0, wake_req}, 32'd0);
        cpu_halted = 1'b1;
        pin_async[116] = 1'b1;
        tick(3);
        check("R9 unimpl no wake", {31'd0, wake_req}, 32'd0);
        pin_dir[0] = 1'b1;
        pin_async[0] = 1'b1;
        tick(3);
        check("R8 output no wake", {31'd0, wake_req}, 32'd0);

        report();
    end
endmodule